// File: doc/BRIEF.md
# Control Word Decoder with Single-Bit Set/Reset

This block sits behind the control address of a parallel I/O controller. Every byte written there is decoded by its top bit. A byte with the top bit set is a mode definition: its lower seven bits are stored as the configuration that the data-port logic reads. A byte with the top bit clear is a single-bit command. It sets or clears one bit of an 8-bit port C register and leaves the stored mode alone.

A mode definition also clears every port C bit, so each new configuration starts from a known state. Single-bit commands are meant for driving individual control lines or enable flags on port C without a read-modify-write. All outputs come straight from flip-flops and change on the clock edge that accepts the write.

Top module: `ctrl_word_unit`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `pc_out` is 0. The mode fields then read all-input basic mode: `grpa_mode`=0, `pa_is_in`=1, `pch_is_in`=1, `grpb_mode`=0, `pb_is_in`=1, `pcl_is_in`=1.
- R2: A write (`cw_wr`=1) with bit 7 = 1 loads the mode fields on that clock edge. Bits 6:5 go to `grpa_mode`, bit 4 to `pa_is_in`, bit 3 to `pch_is_in`, bit 2 to `grpb_mode`, bit 1 to `pb_is_in` and bit 0 to `pcl_is_in`.
- R3: A write with bit 7 = 1 clears all bits of `pc_out` on the same edge.
- R4: A write with bit 7 = 0 and bit 0 = 1 sets the `pc_out` bit whose index is given by bits 3:1.
- R5: A write with bit 7 = 0 and bit 0 = 0 clears the `pc_out` bit whose index is given by bits 3:1.
- R6: A write with bit 7 = 0 changes at most one bit of `pc_out`. The other seven bits keep their values.
- R7: A write with bit 7 = 0 leaves every mode field unchanged.
- R8: In a write with bit 7 = 0, bits 6:4 have no effect on `pc_out` or on the mode fields.
- R9: With `cw_wr` low, `pc_out` and the mode fields hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cw_wr | input | 1 | Control byte write strobe, one cycle per byte |
| cw_data | input | 8 | Control byte |
| pc_out | output | 8 | Port C bit register |
| grpa_mode | output | 2 | Group A mode number |
| pa_is_in | output | 1 | Port A direction, 1 = input |
| pch_is_in | output | 1 | Port C upper half direction, 1 = input |
| grpb_mode | output | 1 | Group B mode number |
| pb_is_in | output | 1 | Port B direction, 1 = input |
| pcl_is_in | output | 1 | Port C lower half direction, 1 = input |

## Verification
Set commands are walked across all eight bit indices starting from an all-zero port C, and clear commands across all eight starting from all ones. A wrong index decode or a wider update then shows up as a neighbouring bit that moves. Mode bytes with alternating bit patterns are written over a non-zero port C, which separates a correct field mapping and the port C clear from swapped fields or a missing clear. Single-bit commands with different junk in bits 6:4 are compared against the same commands with those bits zero, and idle cycles are held to show that nothing moves without a write.

// File: rtl/ctrl_word_pkg.sv
package ctrl_word_pkg;

  localparam int CW_W  = 8;
  localparam int FMT_B = CW_W - 1;

  typedef struct packed {
    logic [1:0] grpa_mode;
    logic       pa_in;
    logic       pch_in;
    logic       grpb_mode;
    logic       pb_in;
    logic       pcl_in;
  } mode_t;

  localparam mode_t MODE_RST = '{grpa_mode: 2'd0, pa_in: 1'b1, pch_in: 1'b1,
                                 grpb_mode: 1'b0, pb_in: 1'b1, pcl_in: 1'b1};

endpackage

// File: rtl/cw_decode.sv
module cw_decode
  import ctrl_word_pkg::*;
#(
  parameter int PC_W  = 8,
  localparam int SEL_W = $clog2(PC_W)
) (
  input  logic             wr,
  input  logic [CW_W-1:0]  data,
  output logic             mode_we,
  output mode_t            mode_val,
  output logic             bit_we,
  output logic [SEL_W-1:0] bit_sel,
  output logic             bit_val
);

  always_comb begin
    mode_we  = wr &  data[FMT_B];
    bit_we   = wr & ~data[FMT_B];
    mode_val = mode_t'(data[FMT_B-1:0]);
    bit_sel  = data[SEL_W:1];
    bit_val  = data[0];
  end

endmodule

// File: rtl/portc_bits.sv
module portc_bits #(
  parameter int PC_W  = 8,
  localparam int SEL_W = $clog2(PC_W)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_all,
  input  logic             bit_we,
  input  logic [SEL_W-1:0] bit_sel,
  input  logic             bit_val,
  output logic [PC_W-1:0]  q
);

  for (genvar i = 0; i < PC_W; i++) begin : g_bit
    localparam logic [SEL_W-1:0] IDX = SEL_W'(i);
    always_ff @(posedge clk) begin
      if (rst || clr_all)
        q[i] <= 1'b0;
      else if (bit_we && (bit_sel == IDX))
        q[i] <= bit_val;
    end
  end

endmodule

// File: rtl/mode_reg.sv
module mode_reg
  import ctrl_word_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  we,
  input  mode_t d,
  output mode_t q
);

  always_ff @(posedge clk) begin
    if (rst)
      q <= MODE_RST;
    else if (we)
      q <= d;
  end

endmodule

// File: rtl/ctrl_word_unit.sv
module ctrl_word_unit
  import ctrl_word_pkg::*;
#(
  parameter int PC_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cw_wr,
  input  logic [7:0]      cw_data,
  output logic [PC_W-1:0] pc_out,
  output logic [1:0]      grpa_mode,
  output logic            pa_is_in,
  output logic            pch_is_in,
  output logic            grpb_mode,
  output logic            pb_is_in,
  output logic            pcl_is_in
);

  localparam int SEL_W = $clog2(PC_W);

  logic             mode_we;
  mode_t            mode_d;
  mode_t            mode_q;
  logic             bit_we;
  logic [SEL_W-1:0] bit_sel;
  logic             bit_val;

  cw_decode #(.PC_W(PC_W)) u_dec (
    .wr       (cw_wr),
    .data     (cw_data),
    .mode_we  (mode_we),
    .mode_val (mode_d),
    .bit_we   (bit_we),
    .bit_sel  (bit_sel),
    .bit_val  (bit_val)
  );

  portc_bits #(.PC_W(PC_W)) u_pc (
    .clk     (clk),
    .rst     (rst),
    .clr_all (mode_we),
    .bit_we  (bit_we),
    .bit_sel (bit_sel),
    .bit_val (bit_val),
    .q       (pc_out)
  );

  mode_reg u_mode (
    .clk (clk),
    .rst (rst),
    .we  (mode_we),
    .d   (mode_d),
    .q   (mode_q)
  );

  always_comb begin
    grpa_mode = mode_q.grpa_mode;
    pa_is_in  = mode_q.pa_in;
    pch_is_in = mode_q.pch_in;
    grpb_mode = mode_q.grpb_mode;
    pb_is_in  = mode_q.pb_in;
    pcl_is_in = mode_q.pcl_in;
  end

endmodule

// File: rtl/ctrl_word_chk.sv
module ctrl_word_chk (
  input logic       clk,
  input logic       rst,
  input logic       cw_wr,
  input logic [7:0] cw_data,
  input logic [7:0] pc_out,
  input logic [1:0] grpa_mode,
  input logic       pa_is_in,
  input logic       pch_is_in,
  input logic       grpb_mode,
  input logic       pb_is_in,
  input logic       pcl_is_in
);

  logic [6:0] mode_v;
  logic       armed = 1'b0;

  assign mode_v = {grpa_mode, pa_is_in, pch_is_in, grpb_mode, pb_is_in, pcl_is_in};

  always_ff @(posedge clk) armed <= ~rst;

  // R1
  reset_state_chk: assert property (@(posedge clk)
    $past(rst) |-> (pc_out == 8'h00 && mode_v == 7'h1B));

  // R2
  mode_load_chk: assert property (@(posedge clk) disable iff (rst)
    (armed && cw_wr && cw_data[7]) |=> (mode_v == $past(cw_data[6:0])));

  // R3
  mode_clears_pc_chk: assert property (@(posedge clk) disable iff (rst)
    (armed && cw_wr && cw_data[7]) |=> (pc_out == 8'h00));

  // R4
  bit_set_chk: assert property (@(posedge clk) disable iff (rst)
    (armed && cw_wr && !cw_data[7] && cw_data[0]) |=> pc_out[$past(cw_data[3:1])]);

  // R5
  bit_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (armed && cw_wr && !cw_data[7] && !cw_data[0]) |=> !pc_out[$past(cw_data[3:1])]);

  // R6
  one_bit_chk: assert property (@(posedge clk) disable iff (rst)
    (armed && cw_wr && !cw_data[7]) |=> ($countones(pc_out ^ $past(pc_out)) <= 1));

  // R7
  sr_keeps_mode_chk: assert property (@(posedge clk) disable iff (rst)
    (armed && cw_wr && !cw_data[7]) |=> $stable(mode_v));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (armed && !cw_wr) |=> ($stable(pc_out) && $stable(mode_v)));

endmodule

bind ctrl_word_unit ctrl_word_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .cw_wr     (cw_wr),
  .cw_data   (cw_data),
  .pc_out    (pc_out),
  .grpa_mode (grpa_mode),
  .pa_is_in  (pa_is_in),
  .pch_is_in (pch_is_in),
  .grpb_mode (grpb_mode),
  .pb_is_in  (pb_is_in),
  .pcl_is_in (pcl_is_in)
);

// File: tb/tb_ctrl_word_unit.sv
module tb_ctrl_word_unit;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cw_wr = 1'b0;
  logic [7:0] cw_data = 8'h00;
  logic [7:0] pc_out;
  logic [1:0] grpa_mode;
  logic       pa_is_in, pch_is_in, grpb_mode, pb_is_in, pcl_is_in;

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] exp_pc;
  logic [6:0] exp_mode;

  always #10 clk = ~clk;

  ctrl_word_unit dut (
    .clk (clk), .rst (rst), .cw_wr (cw_wr), .cw_data (cw_data),
    .pc_out (pc_out), .grpa_mode (grpa_mode), .pa_is_in (pa_is_in),
    .pch_is_in (pch_is_in), .grpb_mode (grpb_mode), .pb_is_in (pb_is_in),
    .pcl_is_in (pcl_is_in)
  );

  function automatic logic [6:0] mode_now();
    return {grpa_mode, pa_is_in, pch_is_in, grpb_mode, pb_is_in, pcl_is_in};
  endfunction

  task automatic check(input string req, input logic [7:0] got_pc, input logic [6:0] got_mode);
    n_chk++;
    if (got_pc !== exp_pc || got_mode !== exp_mode) begin
      n_fail++;
      $display("FAIL %s: pc=%h mode=%h expected pc=%h mode=%h",
               req, got_pc, got_mode, exp_pc, exp_mode);
    end
  endtask

  // one-cycle write driven at negedge; outputs settle at the following posedge
  task automatic put(input logic [7:0] b);
    @(negedge clk);
    cw_wr = 1'b1; cw_data = b;
    @(negedge clk);
    cw_wr = 1'b0; cw_data = 8'h00;
  endtask

  task automatic model(input logic [7:0] b);
    if (b[7]) begin
      exp_mode = b[6:0];
      exp_pc = 8'h00;
    end else begin
      exp_pc[b[3:1]] = b[0];
    end
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    exp_pc = 8'h00; exp_mode = 7'h1B;
    check("R1 in reset", pc_out, mode_now());
    rst = 1'b0;
    @(negedge clk);
    check("R1 after reset", pc_out, mode_now());
  endtask

  task automatic t_mode_patterns();
    logic [7:0] pats [4] = '{8'hD5, 8'hAA, 8'h80, 8'hFF};
    for (int k = 0; k < 4; k++) begin
      put(8'h0F); model(8'h0F);           // put a 1 on pc[7]
      put(pats[k]); model(pats[k]);
      check("R2 R3 mode write", pc_out, mode_now());
    end
  endtask

  task automatic t_set_walk();
    put(8'h80); model(8'h80);
    for (int i = 0; i < 8; i++) begin
      logic [7:0] b = {4'b0000, 3'(i), 1'b1};
      put(b); model(b);
      check("R4 R6 R7 set", pc_out, mode_now());
    end
  endtask

  task automatic t_clr_walk();
    for (int i = 7; i >= 0; i--) begin
      logic [7:0] b = {4'b0000, 3'(i), 1'b0};
      put(b); model(b);
      check("R5 R6 R7 clear", pc_out, mode_now());
    end
  endtask

  task automatic t_ignore_hi();
    logic [7:0] cmds [4] = '{8'h75, 8'h3B, 8'h40, 8'h6E};
    put(8'h9B); model(8'h9B);
    for (int k = 0; k < 4; k++) begin
      put(cmds[k]); model({4'b0000, cmds[k][3:0]});
      check("R8 upper bits ignored", pc_out, mode_now());
    end
  endtask

  task automatic t_idle();
    put(8'h07); model(8'h07);
    repeat (6) @(negedge clk);
    cw_data = 8'hFF;                       // data present but no strobe
    repeat (3) @(negedge clk);
    cw_data = 8'h00;
    check("R9 hold without write", pc_out, mode_now());
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not complete");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    t_mode_patterns();
    t_set_walk();
    t_clr_walk();
    t_ignore_hi();
    t_idle();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule